// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is one timer channel with a 16-bit up-counter. The counter advances on ticks from a selectable prescaler. Two general registers, A and B, sit beside the counter. Each one can work either as a compare register or as a capture register.

- **Compare role.** A match drives the register's own output pin low, drives it high, or toggles it.
- **Capture role.** A chosen edge on the register's input pin latches the counter value.
- **Shadow registers.** Two shadow registers, C and D, pair with A and B. In compare role a shadow reloads its compare value, either at the match or when the counter is cleared. In capture role the value displaced by a capture moves into the shadow.
- **Periodic counting.** Either channel's event can be chosen to zero the counter, which gives a periodic count.
- **Interrupts.** Overflow and per-channel events each produce a one-cycle interrupt pulse. Each pulse has its own enable.

Software programs the channel through a simple one-cycle write port. The counter, the general registers and the shadow registers are visible on output ports.

Top module: `cc_timer_chan`

## Requirements
- R1: The counter increments by one on each prescaler tick while the run bit (control word bit 0) is 1. It wraps from FFFFh to 0000h. It holds its value while the run bit is 0.
- R2: Control bits [2:1] select the tick rate: 0 = every cycle, 1 = every 4th cycle, 2 = every 16th cycle, 3 = every 64th cycle. The first tick comes that many cycles after the run bit is set.
- R3: A wrap from FFFFh raises a one-cycle `irq_ovf` pulse in the following cycle, but only when interrupt-enable bit 0 is set.
- R4: Control bits [4:3] pick the clear source: 0 = none, 1 = channel A event, 2 = channel B event. A compare match on the source at value N zeroes the counter instead of incrementing it, so the period is N+1 ticks.
- R5: Channel config action bits [1:0] (A at bits [5:0] of word 1, B at bits [13:8]) set the pin effect of a compare match: 0 = none, 1 = low, 2 = high, 3 = toggle. The match happens on a tick where the counter equals the general register, and the pin changes at that clock edge. A pin already at the requested level stays put.
- R6: With capture mode (config bit 4) set, edge bits [3:2] select the edge: 1 = rising, 2 = falling, 3 = both. The pin goes through a two-flop synchronizer. The general register takes the counter value present two cycles after the pin changes. Edges that are not selected are ignored.
- R7: With shadowing (config bit 5) set in compare mode and transfer-at-clear off, every compare match copies the shadow into the general register.
- R8: With shadowing set in capture mode, a capture stores the counter in the general register. In the same cycle it moves the previous general value into the shadow.
- R9: With the transfer-at-clear bit (control bit 5) set, compare-mode shadow copies happen only on counter clears. A counter clear is a wrap, a write of 0000h while running, or a clear from the clear source. A compare match alone does not copy.
- R10: A write to control bit 5 takes effect only when the counter was stopped. While running, the old value is kept.
- R11: A compare match or capture on a channel gives a one-cycle pulse on that channel's interrupt in the next cycle, only if its enable bit is set (bit 1 = A, bit 2 = B).
- R12: The write address map is: 0 control, 1 channel config, 2 interrupt enables, 3 counter, 4/5 general A/B, 6/7 shadow C/D. The counter read port shows written values directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cap_a_in | input | 1 | Capture input for channel A |
| cap_b_in | input | 1 | Capture input for channel B |
| pin_a | output | 1 | Compare output pin of channel A |
| pin_b | output | 1 | Compare output pin of channel B |
| irq_ovf | output | 1 | Overflow interrupt pulse |
| irq_a | output | 1 | Channel A event interrupt pulse |
| irq_b | output | 1 | Channel B event interrupt pulse |
| count_o | output | 16 | Current counter value |
| gen_a_o | output | 16 | General register A |
| gen_b_o | output | 16 | General register B |
| buf_c_o | output | 16 | Shadow register C |
| buf_d_o | output | 16 | Shadow register D |

## Verification
The counter is exercised in several ways, and each scenario separates one pair of behaviours:
- Free-running near FFFFh, with and without the overflow enable, separates the wrap and its pulse gating.
- Prescaled runs at divide-by-4 and divide-by-64 are sampled one cycle before and at the expected tick, which catches off-by-one dividers.
- Periodic runs with toggle, set-high and set-low actions separate match timing from clearing.

The shadow tests contrast the two transfer modes on the same pattern. In match mode a reload follows the match. In clear mode a later match must leave the register untouched, while a wrap and a zero write both reload it. A mode bit written mid-run must be ignored. Capture runs drive rising, falling and both-edge patterns against a known count, so both the synchronizer latency and the shadow shift are checked.

// File: rtl/cct_pkg.sv
package cct_pkg;
   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } pin_act_e;

   typedef struct packed {
      logic       buf_en;
      logic       cap_mode;
      logic [1:0] edge_sel;
      pin_act_e   act;
   } chan_cfg_t;

   localparam int CFG_W = $bits(chan_cfg_t);

   localparam logic [2:0] A_CTRL     = 3'd0;
   localparam logic [2:0] A_CHCFG    = 3'd1;
   localparam logic [2:0] A_IEN      = 3'd2;
   localparam logic [2:0] A_CNT      = 3'd3;
   localparam int         A_GEN_BASE = 4;
   localparam int         A_BUF_BASE = 6;
endpackage

// File: rtl/cct_prescale.sv
module cct_prescale #(
   parameter int PRE_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   generate
      if (PRE_W < 6) begin : g_pre_chk
         $error("PRE_W must hold a divide-by-64 count");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_comb begin
      case (sel)
         2'd0:    mask = '0;
         2'd1:    mask = PRE_W'(3);
         2'd2:    mask = PRE_W'(15);
         default: mask = PRE_W'(63);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) pre_q <= '0;
      else                pre_q <= pre_q + 1'b1;
   end

   assign tick = run && ((pre_q & mask) == mask);
endmodule

// File: rtl/cct_insync.sv
module cct_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_stage_chk
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise =  sh_q[STAGES-1] && !sh_q[STAGES];
   assign fall = !sh_q[STAGES-1] &&  sh_q[STAGES];
endmodule

// File: rtl/cct_unit.sv
module cct_unit
   import cct_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  chan_cfg_t    cfg,
   input  logic [W-1:0] count,
   input  logic         tick,
   input  logic         rise,
   input  logic         fall,
   input  logic         clr_evt,
   input  logic         xfer_at_clr,
   input  logic         wr_gen,
   input  logic         wr_buf,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] gen,
   output logic [W-1:0] bufr,
   output logic         pin,
   output logic         hit,
   output logic         cap
);
   logic reload;

   assign hit    = !cfg.cap_mode && tick && (count == gen);
   assign cap    =  cfg.cap_mode && ((cfg.edge_sel[0] && rise) || (cfg.edge_sel[1] && fall));
   assign reload = !cfg.cap_mode && cfg.buf_en && (xfer_at_clr ? clr_evt : hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen  <= '0;
         bufr <= '0;
      end else begin
         if (cap) begin
            gen <= count;
            if (cfg.buf_en) bufr <= gen;
            else if (wr_buf) bufr <= wr_data;
         end else begin
            if (reload)      gen <= bufr;
            else if (wr_gen) gen <= wr_data;
            if (wr_buf)      bufr <= wr_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else if (hit) begin
         case (cfg.act)
            ACT_LOW:    pin <= 1'b0;
            ACT_HIGH:   pin <= 1'b1;
            ACT_TOGGLE: pin <= !pin;
            default:    pin <= pin;
         endcase
      end
   end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
   import cct_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 6,
   parameter int SYNC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             cap_a_in,
   input  logic             cap_b_in,
   output logic             pin_a,
   output logic             pin_b,
   output logic             irq_ovf,
   output logic             irq_a,
   output logic             irq_b,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] gen_a_o,
   output logic [CNT_W-1:0] gen_b_o,
   output logic [CNT_W-1:0] buf_c_o,
   output logic [CNT_W-1:0] buf_d_o
);
   localparam int               NCH     = 2;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 16) begin : g_w_chk
         $error("CNT_W must be at least 16 to hold the config fields");
      end
   endgenerate

   logic             run_q, xfer_q;
   logic [1:0]       pre_sel_q, clr_src_q;
   logic [2:0]       ien_q;
   chan_cfg_t        cfg_q [NCH];
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] gen_v [NCH];
   logic [CNT_W-1:0] buf_v [NCH];
   logic [NCH-1:0]   hit_v, cap_v, pin_v, irq_ch_q;
   logic [NCH-1:0]   cap_pins;
   logic             tick, src_hit, ovf, clr_evt, irq_ovf_q;
   logic             wr_ctrl, wr_cfg, wr_ien, wr_cnt;

   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_cfg   = wr_en && (wr_addr == A_CHCFG);
   assign wr_ien   = wr_en && (wr_addr == A_IEN);
   assign wr_cnt   = wr_en && (wr_addr == A_CNT);
   assign cap_pins = {cap_b_in, cap_a_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         xfer_q    <= 1'b0;
         pre_sel_q <= '0;
         clr_src_q <= '0;
         ien_q     <= '0;
         cfg_q[0]  <= '0;
         cfg_q[1]  <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q     <= wr_data[0];
            pre_sel_q <= wr_data[2:1];
            clr_src_q <= wr_data[4:3];
            if (!run_q) xfer_q <= wr_data[5];
         end
         if (wr_cfg) begin
            cfg_q[0] <= chan_cfg_t'(wr_data[CFG_W-1:0]);
            cfg_q[1] <= chan_cfg_t'(wr_data[8+CFG_W-1:8]);
         end
         if (wr_ien) ien_q <= wr_data[2:0];
      end
   end

   cct_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .sel(pre_sel_q), .tick(tick)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic rise, fall;
         cct_insync #(.STAGES(SYNC)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin(cap_pins[i]), .rise(rise), .fall(fall)
         );
         cct_unit #(.W(CNT_W)) u_unit (
            .clk(clk), .rst_n(rst_n), .cfg(cfg_q[i]), .count(count_q), .tick(tick),
            .rise(rise), .fall(fall), .clr_evt(clr_evt), .xfer_at_clr(xfer_q),
            .wr_gen(wr_en && (wr_addr == 3'(A_GEN_BASE + i))),
            .wr_buf(wr_en && (wr_addr == 3'(A_BUF_BASE + i))),
            .wr_data(wr_data), .gen(gen_v[i]), .bufr(buf_v[i]),
            .pin(pin_v[i]), .hit(hit_v[i]), .cap(cap_v[i])
         );
      end
   endgenerate

   always_comb begin
      case (clr_src_q)
         2'd1:    src_hit = hit_v[0] || cap_v[0];
         2'd2:    src_hit = hit_v[1] || cap_v[1];
         default: src_hit = 1'b0;
      endcase
   end

   assign ovf     = tick && (count_q == CNT_MAX) && !src_hit && !wr_cnt;
   assign clr_evt = ovf || (src_hit && !wr_cnt) || (wr_cnt && run_q && (wr_data == '0));

   always_ff @(posedge clk) begin
      if (!rst_n)       count_q <= '0;
      else if (wr_cnt)  count_q <= wr_data;
      else if (src_hit) count_q <= '0;
      else if (tick)    count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_ovf_q <= 1'b0;
         irq_ch_q  <= '0;
      end else begin
         irq_ovf_q <= ovf && ien_q[0];
         irq_ch_q  <= (hit_v | cap_v) & ien_q[2:1];
      end
   end

   assign irq_ovf = irq_ovf_q;
   assign irq_a   = irq_ch_q[0];
   assign irq_b   = irq_ch_q[1];
   assign pin_a   = pin_v[0];
   assign pin_b   = pin_v[1];
   assign count_o = count_q;
   assign gen_a_o = gen_v[0];
   assign gen_b_o = gen_v[1];
   assign buf_c_o = buf_v[0];
   assign buf_d_o = buf_v[1];
endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_q,
   input logic             xfer_q,
   input logic             wr_cnt,
   input logic             src_hit,
   input logic [CNT_W-1:0] count,
   input logic             irq_ovf,
   input logic             irq_a,
   input logic             irq_b,
   input logic             pin_a,
   input logic             pin_b,
   input logic [1:0]       hit,
   input logic [2:0]       ien
);
   // R1
   hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_cnt && !src_hit) |=> $stable(count));

   // R3
   ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> $past(ien[0]));

   // R3
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> (count == '0 || $past(wr_cnt)));

   // R5
   pin_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_a) |-> $past(hit[0]));

   // R5
   pin_b_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_b) |-> $past(hit[1]));

   // R11
   irq_a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> $past(ien[1]));

   // R11
   irq_b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> $past(ien[2]));

   // R10
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(xfer_q));
endmodule

bind cc_timer_chan cct_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_q(run_q), .xfer_q(xfer_q), .wr_cnt(wr_cnt),
   .src_hit(src_hit), .count(count_o), .irq_ovf(irq_ovf), .irq_a(irq_a),
   .irq_b(irq_b), .pin_a(pin_a), .pin_b(pin_b), .hit(hit_v), .ien(ien_q)
);

// File: tb/sim_cc_timer_chan.sv
module sim_cc_timer_chan;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        cap_a_in = 1'b0, cap_b_in = 1'b0;
   logic        pin_a, pin_b, irq_ovf, irq_a, irq_b;
   logic [15:0] count_o, gen_a_o, gen_b_o, buf_c_o, buf_d_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      string       req;
      int          sel;
      logic [15:0] exp;
   } item_t;
   item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cc_timer_chan u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cap_a_in(cap_a_in), .cap_b_in(cap_b_in), .pin_a(pin_a), .pin_b(pin_b),
      .irq_ovf(irq_ovf), .irq_a(irq_a), .irq_b(irq_b), .count_o(count_o),
      .gen_a_o(gen_a_o), .gen_b_o(gen_b_o), .buf_c_o(buf_c_o), .buf_d_o(buf_d_o)
   );

   function automatic logic [15:0] pick(int sel);
      case (sel)
         0: return count_o;
         1: return gen_a_o;
         2: return gen_b_o;
         3: return buf_c_o;
         4: return buf_d_o;
         5: return {15'd0, pin_a};
         6: return {15'd0, pin_b};
         7: return {15'd0, irq_ovf};
         8: return {15'd0, irq_a};
         default: return {15'd0, irq_b};
      endcase
   endfunction

   // monitor: pops expected items and compares with the live outputs
   initial begin
      forever begin
         item_t it;
         logic [15:0] act;
         wait (sb_q.size() != 0);
         it  = sb_q.pop_front();
         act = pick(it.sel);
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: output %0d actual %h expected %h", it.req, it.sel, act, it.exp);
         end
      end
   end

   task automatic expect_out(input string req, input int sel, input logic [15:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      sb_q.push_back(it);
      #1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      cap_a_in = 1'b0; cap_b_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      step(4);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1: watchdog expired actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] c0, c1;
      do_reset();
      // R12 reset state
      expect_out("R12 reset count", 0, 16'h0000);
      expect_out("R12 reset gen_a", 1, 16'h0000);
      expect_out("R5 reset pin_a", 5, 16'h0000);

      // R1 R3 wrap with overflow enabled
      wr(3'd2, 16'h0001);
      wr(3'd3, 16'hFFFE);
      wr(3'd0, 16'h0001);
      step(1);
      expect_out("R1 count before wrap", 0, 16'hFFFF);
      expect_out("R3 no early ovf", 7, 16'h0000);
      step(1);
      expect_out("R1 wrap to zero", 0, 16'h0000);
      expect_out("R3 ovf pulse", 7, 16'h0001);
      step(1);
      expect_out("R3 ovf one cycle", 7, 16'h0000);
      // R1 stop holds
      wr(3'd0, 16'h0000);
      c0 = count_o;
      step(5);
      expect_out("R1 hold while stopped", 0, c0);

      // R3 overflow disabled
      do_reset();
      wr(3'd3, 16'hFFFF);
      wr(3'd0, 16'h0001);
      step(1);
      expect_out("R3 wrap no enable count", 0, 16'h0000);
      expect_out("R3 no ovf when disabled", 7, 16'h0000);

      // R2 divide by 4
      do_reset();
      wr(3'd0, 16'h0003);
      step(3);
      expect_out("R2 div4 before tick", 0, 16'h0000);
      step(1);
      expect_out("R2 div4 first tick", 0, 16'h0001);
      step(3);
      expect_out("R2 div4 hold", 0, 16'h0001);
      step(1);
      expect_out("R2 div4 second tick", 0, 16'h0002);

      // R2 divide by 64
      do_reset();
      wr(3'd0, 16'h0007);
      step(63);
      expect_out("R2 div64 before tick", 0, 16'h0000);
      step(1);
      expect_out("R2 div64 tick", 0, 16'h0001);

      // R4 R5 R11 periodic toggle on A
      do_reset();
      wr(3'd1, 16'h0003);
      wr(3'd4, 16'd5);
      wr(3'd2, 16'h0002);
      wr(3'd0, 16'h0009);
      step(5);
      expect_out("R4 count at cycle value", 0, 16'd5);
      expect_out("R11 no irq before match", 8, 16'h0000);
      step(1);
      expect_out("R4 clear on match", 0, 16'd0);
      expect_out("R5 toggle high", 5, 16'h0001);
      expect_out("R11 irq_a pulse", 8, 16'h0001);
      step(1);
      expect_out("R4 restart", 0, 16'd1);
      expect_out("R11 irq one cycle", 8, 16'h0000);
      step(5);
      expect_out("R5 toggle low", 5, 16'h0000);

      // R4 R5 set-high on A, set-low on B, clear on B
      do_reset();
      wr(3'd1, 16'h0102);
      wr(3'd4, 16'd2);
      wr(3'd5, 16'd4);
      wr(3'd0, 16'h0011);
      step(3);
      expect_out("R5 set high", 5, 16'h0001);
      step(2);
      expect_out("R4 clear on B", 0, 16'd0);
      expect_out("R5 low already low", 6, 16'h0000);
      step(5);
      expect_out("R5 high stays high", 5, 16'h0001);
      expect_out("R4 second period", 0, 16'd0);

      // R7 shadow reload at match
      do_reset();
      wr(3'd1, 16'h0020);
      wr(3'd4, 16'd3);
      wr(3'd6, 16'd6);
      wr(3'd0, 16'h0009);
      step(4);
      expect_out("R7 clear at first match", 0, 16'd0);
      expect_out("R7 reload at match", 1, 16'd6);
      step(6);
      expect_out("R7 new period count", 0, 16'd6);
      step(1);
      expect_out("R7 match on reloaded value", 0, 16'd0);

      // R9 shadow reload at counter clear
      do_reset();
      wr(3'd0, 16'h0020);
      wr(3'd1, 16'h2000);
      wr(3'd5, 16'd10);
      wr(3'd7, 16'd20);
      wr(3'd3, 16'hFFFD);
      wr(3'd0, 16'h0021);
      step(2);
      expect_out("R9 no reload before wrap", 2, 16'd10);
      step(1);
      expect_out("R9 reload on wrap", 2, 16'd20);
      wr(3'd7, 16'd30);
      wr(3'd3, 16'h0000);
      expect_out("R9 reload on zero write", 2, 16'd30);
      wr(3'd7, 16'd40);
      step(40);
      expect_out("R9 match does not reload", 2, 16'd30);

      // R10 transfer bit ignored while running
      do_reset();
      wr(3'd1, 16'h0020);
      wr(3'd4, 16'd3);
      wr(3'd6, 16'd7);
      wr(3'd0, 16'h0001);
      wr(3'd0, 16'h0021);
      step(3);
      expect_out("R10 mode write ignored", 1, 16'd7);

      // R6 R11 capture rising on A
      do_reset();
      wr(3'd1, 16'h0014);
      wr(3'd2, 16'h0002);
      wr(3'd0, 16'h0001);
      step(5);
      c0 = count_o;
      cap_a_in = 1'b1;
      step(2);
      expect_out("R6 no capture before sync", 8, 16'h0000);
      step(1);
      expect_out("R6 rising capture", 1, c0 + 16'd2);
      expect_out("R11 capture irq", 8, 16'h0001);
      cap_a_in = 1'b0;
      step(5);
      expect_out("R6 falling ignored", 1, c0 + 16'd2);

      // R8 R4 capture both edges on B with shadow, clear on B
      do_reset();
      wr(3'd1, 16'h3C00);
      wr(3'd0, 16'h0011);
      step(5);
      c0 = count_o;
      cap_b_in = 1'b1;
      step(3);
      expect_out("R8 capture rising", 2, c0 + 16'd2);
      expect_out("R8 shadow gets old value", 4, 16'd0);
      expect_out("R4 capture clears counter", 0, 16'd0);
      step(6);
      c1 = count_o;
      cap_b_in = 1'b0;
      step(3);
      expect_out("R6 capture falling", 2, c1 + 16'd2);
      expect_out("R8 shadow shift", 4, c0 + 16'd2);

      done = 1'b1;
      #1;
      summary();
      $finish;
   end
endmodule